// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives an output clock from the input clock. A 3-bit ratio code and a disable bit select the output. Codes 0 to 6 divide the clock by an even ratio of 2, 4, up to 14, and the output keeps a 50 percent duty cycle. Code 7 passes the input clock through unchanged. The disable bit holds the output low whatever the code is.

A write strobe loads the code and the disable bit into a pending setting. The pending setting replaces the active one only at an output period boundary. The phase in progress therefore always completes, and a change of setting never produces a shortened pulse. In divide mode the boundary is the end of a low phase. In pass-through mode and in the disabled state, any rising input edge is a boundary. When the block enters divide mode it starts with a full high phase.

Top module: `clkout_divider`

## Requirements
- R1: After reset the block is disabled and `clk_o` is low.
- R2: A code c from 0 to 6 (disable bit 0) gives an output period of 2*(c+1) input clock cycles.
- R3: In divide mode the output is high for c+1 cycles and low for c+1 cycles. It changes only on rising input edges, so no glitch occurs inside an input cycle.
- R4: Code 7 (disable bit 0) makes `clk_o` follow the input clock: high in the high phase and low in the low phase of every input cycle.
- R5: When the disable bit is 1, `clk_o` is held low for any code value. A high phase that is already running completes before the output stays low.
- R6: A new setting takes effect only at a period boundary. In divide mode this is the rising edge at which the output would go high again, so the current high and low phases both run to full length.
- R7: When the setting changes from one divide ratio to another, no high or low pulse is shorter than the smaller of the old and new half periods.
- R8: Writing the setting that is already active leaves the waveform unchanged.
- R9: On entry into divide mode the output goes high at the boundary edge and stays high for c+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the setting |
| cfg_code_i | input | 3 | Ratio code: 0 to 6 gives an even ratio, 7 gives pass-through |
| cfg_off_i | input | 1 | Disable bit: 1 holds the output low |
| clk_o | output | 1 | Output clock |

## Verification
Every divide code is run in steady state. High and low run lengths are measured at two sample points in each input cycle, which checks the ratio, the duty cycle and the absence of glitches inside an input cycle. Two writes are placed exactly on a freshly started high phase: a change from ratio 14 to ratio 2, and a change from ratio 6 to disabled. Their cycle-exact expected waveforms separate a setting applied at the boundary from one applied at once. Every ordered pair of divide codes is swept with the write at varying phase offsets to check the minimum pulse width. Further cases cover entry from the disabled state, pass-through, disabling with a nonzero code, and repeated writes of the active setting.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PASS = 2'd1,
    MODE_DIV  = 2'd2
  } ckdiv_mode_e;
endpackage

// File: rtl/ckdiv_cfg.sv
module ckdiv_cfg
  import ckdiv_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              off_i,
  output ckdiv_mode_e       pend_mode_o,
  output logic [CODE_W-1:0] pend_half_o
);
  localparam logic [CODE_W-1:0] PASS_CODE = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] ONE       = CODE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_mode_o <= MODE_OFF;
      pend_half_o <= ONE;
    end else if (we_i) begin
      if (off_i) begin
        pend_mode_o <= MODE_OFF;
        pend_half_o <= ONE;
      end else if (code_i == PASS_CODE) begin
        pend_mode_o <= MODE_PASS;
        pend_half_o <= ONE;
      end else begin
        pend_mode_o <= MODE_DIV;
        pend_half_o <= code_i + ONE;
      end
    end
  end

  a_r2_half_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_mode_o == MODE_DIV) |-> (pend_half_o != '0));
endmodule

// File: rtl/ckdiv_core.sv
module ckdiv_core
  import ckdiv_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ckdiv_mode_e       pend_mode_i,
  input  logic [CODE_W-1:0] pend_half_i,
  output logic              div_o,
  output logic              pass_arm_o
);
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  ckdiv_mode_e       act_mode_q;
  logic [CODE_W-1:0] act_half_q;
  logic [CODE_W-1:0] cnt_q;
  logic              div_q;
  logic              at_limit;
  logic              boundary;
  logic              changed;
  logic              apply;

  assign at_limit = (cnt_q == act_half_q - ONE);

  // Divide mode: boundary is the edge where the output would rise again
  always_comb begin
    unique case (act_mode_q)
      MODE_DIV: boundary = at_limit && !div_q;
      default:  boundary = 1'b1;
    endcase
  end

  assign changed = (pend_mode_i != act_mode_q) ||
                   ((pend_mode_i == MODE_DIV) && (pend_half_i != act_half_q));
  assign apply   = boundary && changed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_mode_q <= MODE_OFF;
      act_half_q <= ONE;
      cnt_q      <= '0;
      div_q      <= 1'b0;
    end else if (apply) begin
      act_mode_q <= pend_mode_i;
      act_half_q <= pend_half_i;
      cnt_q      <= '0;
      div_q      <= (pend_mode_i == MODE_DIV);
    end else if (act_mode_q == MODE_DIV) begin
      if (at_limit) begin
        cnt_q <= '0;
        div_q <= ~div_q;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign div_o      = div_q;
  assign pass_arm_o = (act_mode_q == MODE_PASS);

  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_q == MODE_DIV) |-> (cnt_q < act_half_q));

  a_r3_toggle_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_mode_q == MODE_DIV) && ($past(act_mode_q) == MODE_DIV) && (div_q != $past(div_q)))
    |-> ($past(cnt_q) == $past(act_half_q) - ONE));

  a_r5_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_q == MODE_OFF) |-> !div_q);

  a_r6_switch_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode_q != $past(act_mode_q)) |-> $past(boundary));

  a_r9_div_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_mode_q == MODE_DIV) && ($past(act_mode_q) != MODE_DIV)) |-> div_q);
endmodule

// File: rtl/ckdiv_out.sv
module ckdiv_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_i,
  input  logic pass_arm_i,
  output logic clk_o
);
  logic pass_en_q;

  // Enable changes only while clk_i is low, so the gated path cannot clip a high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_en_q <= 1'b0;
    else         pass_en_q <= pass_arm_i;
  end

  assign clk_o = (clk_i & pass_en_q) | div_i;

  a_r4_paths_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_en_q && div_i));
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import ckdiv_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              cfg_off_i,
  output logic              clk_o
);
  ckdiv_mode_e       pend_mode;
  logic [CODE_W-1:0] pend_half;
  logic              div;
  logic              pass_arm;

  ckdiv_cfg #(.CODE_W(CODE_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .code_i      (cfg_code_i),
    .off_i       (cfg_off_i),
    .pend_mode_o (pend_mode),
    .pend_half_o (pend_half)
  );

  ckdiv_core #(.CODE_W(CODE_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_mode_i (pend_mode),
    .pend_half_i (pend_half),
    .div_o       (div),
    .pass_arm_o  (pass_arm)
  );

  ckdiv_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (div),
    .pass_arm_i (pass_arm),
    .clk_o      (clk_o)
  );

  a_r1_low_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rst_ni)) |-> !clk_o);
endmodule

// File: tb/clkout_divider_tb.sv
`timescale 1ns/1ps
module clkout_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_code = '0;
  logic       cfg_off = 1'b0;
  logic       clk_o;

  int n_chk = 0;
  int n_fail = 0;
  logic hi_s [0:255];
  logic lo_s [0:255];

  always #10 clk = ~clk;

  clkout_divider u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_code_i (cfg_code),
    .cfg_off_i  (cfg_off),
    .clk_o      (clk_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one input cycle: sample in high phase and in low phase
  task automatic sample(input int idx);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    #4 hi_s[idx] = clk_o;
    #10 lo_s[idx] = clk_o;
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) sample(i);
  endtask

  task automatic write_cfg(input int code, input bit off);
    cfg_code = 3'(code);
    cfg_off  = off;
    cfg_we   = 1'b1;
  endtask

  task automatic analyze(input int n, output int minr, output int maxr, output int nr, output bit gl);
    int  len;
    bit  started;
    minr = 999; maxr = 0; nr = 0; gl = 1'b0; len = 0; started = 1'b0;
    for (int i = 0; i < n; i++) if (hi_s[i] !== lo_s[i]) gl = 1'b1;
    for (int i = 1; i < n; i++) begin
      if (hi_s[i] !== hi_s[i-1]) begin
        if (started) begin
          nr++;
          if (len < minr) minr = len;
          if (len > maxr) maxr = len;
        end
        started = 1'b1;
        len = 1;
      end else begin
        len++;
      end
    end
  endtask

  // wait for the first high cycle after a low one (limit 40 cycles)
  task automatic sync_rise();
    logic prev;
    prev = 1'b1;
    for (int i = 0; i < 40; i++) begin
      sample(0);
      if (hi_s[0] === 1'b1 && prev === 1'b0) return;
      prev = hi_s[0];
    end
  endtask

  task automatic watchdog_end();
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    watchdog_end();
  end

  initial begin
    int minr, maxr, nr, bad, h, hb, lim;
    bit gl;
    #35 rst_n = 1'b1;

    // R1: disabled after reset
    capture(8);
    bad = 0;
    for (int i = 0; i < 8; i++) if (hi_s[i] !== 1'b0 || lo_s[i] !== 1'b0) bad++;
    chk(bad == 0, "R1", "output low after reset", bad, 0);

    // R2 R3: steady state for every divide code
    for (int c = 0; c < 7; c++) begin
      h = c + 1;
      write_cfg(c, 1'b0);
      repeat (40) sample(0);
      capture(80);
      analyze(80, minr, maxr, nr, gl);
      chk(maxr == h && nr >= 4, "R2", $sformatf("period code %0d (max run)", c), maxr, h);
      chk(minr == h, "R3", $sformatf("duty code %0d (min run)", c), minr, h);
      chk(!gl, "R3", $sformatf("glitch-free code %0d", c), gl, 0);
    end

    // R8: rewriting the active setting at various phases
    write_cfg(4, 1'b0);
    repeat (30) sample(0);
    for (int i = 0; i < 90; i++) begin
      sample(i);
      if (i % 7 == 3) write_cfg(4, 1'b0);
    end
    analyze(90, minr, maxr, nr, gl);
    chk(minr == 5 && maxr == 5 && !gl, "R8", "rewrite leaves runs unchanged", minr * 10 + maxr, 55);

    // R6: ratio 14 -> ratio 2, write on first high cycle
    write_cfg(6, 1'b0);
    repeat (40) sample(0);
    sync_rise();
    write_cfg(0, 1'b0);
    capture(24);
    bad = 0;
    for (int j = 1; j <= 24; j++) begin
      logic e;
      e = (j <= 6) ? 1'b1 : (j <= 13) ? 1'b0 : (((j - 14) % 2) == 0);
      if (hi_s[j-1] !== e || lo_s[j-1] !== e) bad++;
    end
    chk(bad == 0, "R6", "change waits for boundary (14 -> 2)", bad, 0);

    // R5 R6: ratio 6 -> disabled, high phase completes
    write_cfg(2, 1'b0);
    repeat (30) sample(0);
    sync_rise();
    write_cfg(2, 1'b1);
    capture(20);
    bad = 0;
    for (int j = 1; j <= 20; j++) begin
      logic e;
      e = (j <= 2);
      if (hi_s[j-1] !== e || lo_s[j-1] !== e) bad++;
    end
    chk(bad == 0, "R5", "disable after full high phase", bad, 0);

    // R9: disabled -> code 2 starts with a full high phase
    write_cfg(2, 1'b0);
    capture(10);
    bad = 0;
    for (int j = 1; j <= 10; j++) begin
      logic e;
      e = (j >= 2 && j <= 4) || (j >= 8);
      if (hi_s[j-1] !== e || lo_s[j-1] !== e) bad++;
    end
    chk(bad == 0, "R9", "entry high phase", bad, 0);

    // R4: pass-through
    write_cfg(7, 1'b0);
    repeat (5) sample(0);
    capture(12);
    bad = 0;
    for (int i = 0; i < 12; i++) if (hi_s[i] !== 1'b1 || lo_s[i] !== 1'b0) bad++;
    chk(bad == 0, "R4", "output follows input clock", bad, 0);

    // R5: disable with nonzero code from pass-through
    write_cfg(5, 1'b1);
    repeat (3) sample(0);
    capture(12);
    bad = 0;
    for (int i = 0; i < 12; i++) if (hi_s[i] !== 1'b0 || lo_s[i] !== 1'b0) bad++;
    chk(bad == 0, "R5", "disabled output low", bad, 0);

    // R7: every ordered pair of divide codes at varied phase
    for (int a = 0; a < 7; a++) begin
      for (int b = 0; b < 7; b++) begin
        if (a == b) continue;
        hb = b + 1;
        lim = (a + 1 < hb) ? a + 1 : hb;
        write_cfg(a, 1'b0);
        repeat (30 + ((a * 3 + b) % 13)) sample(0);
        for (int i = 0; i < 110; i++) begin
          sample(i);
          if (i == 20) write_cfg(b, 1'b0);
        end
        analyze(110, minr, maxr, nr, gl);
        chk(minr >= lim && !gl, "R7", $sformatf("min run %0d -> %0d", a, b), minr, lim);
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule